// File: doc/BRIEF.md
# Receive Page Ring Pointer Manager

This block decides where each received packet byte lands in a circular region of buffer memory. The region is built from fixed pages of 256 bytes, and every pointer the block keeps is a page number. The host sets the first page of the ring, the page just past its last page, a read-limit page and the page where the next packet will start. The read-limit page is the oldest page the host has not yet drained. While a packet arrives, the block presents a byte address for every incoming byte. The low eight bits of that address step through the page, and the carry moves it to the next page. After the last page of the ring the address wraps back to the first page.

When the byte address is about to move into the read-limit page, the packet is aborted. A one-cycle flag reports the abort, and the start page is left where it was. A good packet moves the start page to the first page the packet did not touch. A rejected packet is dropped by pulling the byte address back to the start page, so the next packet overwrites it. The memory, CRC checking and the packet header are handled outside this block.

Top module: `rxRingPtrMgr`

## Requirements
- R1: After reset the ring first page is 0x40, the ring end page is 0x80, the read-limit page is 0x40, the start page is 0x41, `wrAddr` reads 0x4100 and `overflowAbort` is low.
- R2: A `pktStart` in the idle state, when the start page differs from the read-limit page, begins reception at address {start page, 0x00}. Each `byteValid` cycle during reception writes its byte at the current `wrAddr`, and `wrAddr` then increases by one. The increase carries from the low 8 bits into the page number.
- R3: A byte written at offset 0xFF of the page just below the ring end page is followed by address {ring first page, 0x00}.
- R4: Suppose a byte is written at offset 0xFF and the page that would follow it equals the read-limit page. Then `overflowAbort` is high for exactly the next cycle and reception ends. `curPage` keeps its value and `wrAddr` returns to {start page, 0x00}.
- R5: A `pktStart` in the idle state, when the start page equals the read-limit page, raises `overflowAbort` for one cycle and starts no reception.
- R6: A `pktGood` during reception sets the start page to the page after the last byte written. When the write offset is 0x00 this is the page the address already points to, so a packet with no bytes leaves the start page unchanged. `wrAddr` becomes {new start page, 0x00}.
- R7: A `pktReject` during reception ends it, leaves `curPage` unchanged and restores `wrAddr` to {start page, 0x00}.
- R8: A host write with `hostWrEn` high takes `hostWrSel` to choose the pointer: 0 is the ring first page, 1 the ring end page, 2 the read-limit page, 3 the start page. A write to the start page also sets `wrAddr` to {data, 0x00}. Host writes take effect only in the idle state and are ignored during reception.
- R9: During reception `pktReject` has priority over `pktGood`, and both have priority over `byteValid` in the same cycle, so the byte in that cycle is not counted. In the idle state, `byteValid` leaves `wrAddr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host pointer write strobe |
| hostWrSel | input | 2 | Pointer select: 0 first, 1 end, 2 read-limit, 3 start |
| hostWrData | input | PAGE_W (8) | Page number to write |
| pktStart | input | 1 | Start of an incoming packet |
| byteValid | input | 1 | A byte is written at `wrAddr` this cycle |
| pktGood | input | 1 | Packet accepted, commit its pages |
| pktReject | input | 1 | Packet rejected, discard its pages |
| wrAddr | output | PAGE_W+OFFS_W (16) | Buffer byte address: page number above, offset below |
| overflowAbort | output | 1 | One-cycle pulse on an abort caused by the read limit |
| curPage | output | PAGE_W (8) | Start page of the next packet |

## Verification
The hardest cases to reach are those where a page carry happens at the same moment as a wrap or a hit on the read-limit page. These occur only after hundreds of bytes have been streamed into the ring. The bench sets up a small ring of four pages. It streams packets long enough to cross a page, wrap through the ring end and run into the read-limit page, and it checks every byte address against a page model that the bench computes itself. It also places host pointer writes in the middle of a packet, so that any write that was wrongly accepted would change a later abort or commit result.

// File: rtl/rxRingPkg.sv
package rxRingPkg;

  // Pointer select codes for host writes
  localparam logic [1:0] SEL_FIRST = 2'd0;
  localparam logic [1:0] SEL_END   = 2'd1;
  localparam logic [1:0] SEL_LIMIT = 2'd2;
  localparam logic [1:0] SEL_START = 2'd3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } rxStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic hostWr;
    logic openPkt;
    logic incWp;
    logic commit;
    logic rollback;
    logic abort;
  } ringStrobeT;

endpackage

// File: rtl/rxRingCtrl.sv
module rxRingCtrl
  import rxRingPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic       pktStart,
  input  logic       byteValid,
  input  logic       pktGood,
  input  logic       pktReject,
  input  logic       crossHitsLimit,
  input  logic       startIsLimit,
  output ringStrobeT strobes,
  output logic       rxActive
);

  rxStateT state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (pktStart) begin
          if (startIsLimit) begin
            strobes.abort = 1'b1;
          end else begin
            strobes.openPkt = 1'b1;
            stateNext       = ST_RECV;
          end
        end else if (hostWrEn) begin
          strobes.hostWr = 1'b1;
        end
      end
      ST_RECV: begin
        if (pktReject) begin
          strobes.rollback = 1'b1;
          stateNext        = ST_IDLE;
        end else if (pktGood) begin
          strobes.commit = 1'b1;
          stateNext      = ST_IDLE;
        end else if (byteValid) begin
          if (crossHitsLimit) begin
            strobes.abort = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            strobes.incWp = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign rxActive = (state == ST_RECV);

endmodule

// File: rtl/rxRingData.sv
module rxRingData
  import rxRingPkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8,
  parameter logic [PAGE_W-1:0] RST_FIRST = 8'h40,
  parameter logic [PAGE_W-1:0] RST_END   = 8'h80,
  parameter logic [PAGE_W-1:0] RST_LIMIT = 8'h40,
  parameter logic [PAGE_W-1:0] RST_START = 8'h41,
  localparam int ADDR_W = PAGE_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobeT        strobes,
  input  logic [1:0]        hostWrSel,
  input  logic [PAGE_W-1:0] hostWrData,
  output logic              crossHitsLimit,
  output logic              startIsLimit,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              overflowAbort,
  output logic [PAGE_W-1:0] curPage
);

  logic [PAGE_W-1:0] firstPg, endPg, limitPg, startPg;
  logic [PAGE_W-1:0] wpPage;
  logic [OFFS_W-1:0] wpOff;
  logic              abortQ;

  logic [PAGE_W-1:0] wpPageNext;
  logic [PAGE_W-1:0] commitPage;
  logic              lastByte;

  function automatic logic [PAGE_W-1:0] stepPage(input logic [PAGE_W-1:0] p,
                                                 input logic [PAGE_W-1:0] ringEnd,
                                                 input logic [PAGE_W-1:0] ringFirst);
    logic [PAGE_W-1:0] inc;
    inc = p + {{(PAGE_W-1){1'b0}}, 1'b1};
    return (inc == ringEnd) ? ringFirst : inc;
  endfunction

  assign lastByte       = &wpOff;
  assign wpPageNext     = stepPage(wpPage, endPg, firstPg);
  assign crossHitsLimit = lastByte && (wpPageNext == limitPg);
  assign startIsLimit   = (startPg == limitPg);
  assign commitPage     = (wpOff == '0) ? wpPage : wpPageNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstPg <= RST_FIRST;
      endPg   <= RST_END;
      limitPg <= RST_LIMIT;
      startPg <= RST_START;
      wpPage  <= RST_START;
      wpOff   <= '0;
      abortQ  <= 1'b0;
    end else begin
      abortQ <= strobes.abort;
      if (strobes.hostWr) begin
        unique case (hostWrSel)
          SEL_FIRST: firstPg <= hostWrData;
          SEL_END:   endPg   <= hostWrData;
          SEL_LIMIT: limitPg <= hostWrData;
          default: begin
            startPg <= hostWrData;
            wpPage  <= hostWrData;
            wpOff   <= '0;
          end
        endcase
      end
      if (strobes.openPkt || strobes.rollback || strobes.abort) begin
        wpPage <= startPg;
        wpOff  <= '0;
      end
      if (strobes.incWp) begin
        if (lastByte) wpPage <= wpPageNext;
        wpOff <= wpOff + {{(OFFS_W-1){1'b0}}, 1'b1};
      end
      if (strobes.commit) begin
        startPg <= commitPage;
        wpPage  <= commitPage;
        wpOff   <= '0;
      end
    end
  end

  assign wrAddr        = {wpPage, wpOff};
  assign overflowAbort = abortQ;
  assign curPage       = startPg;

endmodule

// File: rtl/rxRingPtrMgr.sv
module rxRingPtrMgr
  import rxRingPkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8,
  localparam int ADDR_W = PAGE_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [1:0]        hostWrSel,
  input  logic [PAGE_W-1:0] hostWrData,
  input  logic              pktStart,
  input  logic              byteValid,
  input  logic              pktGood,
  input  logic              pktReject,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              overflowAbort,
  output logic [PAGE_W-1:0] curPage
);

  ringStrobeT strobes;
  logic       rxActive;
  logic       crossHitsLimit;
  logic       startIsLimit;

  rxRingCtrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .hostWrEn      (hostWrEn),
    .pktStart      (pktStart),
    .byteValid     (byteValid),
    .pktGood       (pktGood),
    .pktReject     (pktReject),
    .crossHitsLimit(crossHitsLimit),
    .startIsLimit  (startIsLimit),
    .strobes       (strobes),
    .rxActive      (rxActive)
  );

  rxRingData #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) data_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .hostWrSel     (hostWrSel),
    .hostWrData    (hostWrData),
    .crossHitsLimit(crossHitsLimit),
    .startIsLimit  (startIsLimit),
    .wrAddr        (wrAddr),
    .overflowAbort (overflowAbort),
    .curPage       (curPage)
  );

endmodule

// File: rtl/rxRingPtrMgrChk.sv
module rxRingPtrMgrChk #(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8,
  localparam int ADDR_W = PAGE_W + OFFS_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic              pktGood,
  input logic              pktReject,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              overflowAbort,
  input logic [PAGE_W-1:0] curPage,
  input logic              rxActive
);

  // R2
  byte_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxActive && byteValid && !pktGood && !pktReject && !(&wrAddr[OFFS_W-1:0])
    |=> wrAddr == $past(wrAddr) + {{(ADDR_W-1){1'b0}}, 1'b1});

  // R4
  abort_keeps_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowAbort |-> $stable(curPage) && !rxActive);

  // R6
  commit_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxActive && pktGood && !pktReject && (wrAddr[OFFS_W-1:0] == '0)
    |=> curPage == $past(wrAddr[ADDR_W-1:OFFS_W]));

  // R7
  reject_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxActive && pktReject
    |=> !rxActive && wrAddr == {$past(curPage), {OFFS_W{1'b0}}});

  // R8
  start_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxActive && !pktGood |=> $stable(curPage));

endmodule

bind rxRingPtrMgr rxRingPtrMgrChk #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .byteValid    (byteValid),
  .pktGood      (pktGood),
  .pktReject    (pktReject),
  .wrAddr       (wrAddr),
  .overflowAbort(overflowAbort),
  .curPage      (curPage),
  .rxActive     (rxActive)
);

// File: tb/rxRingPtrMgr_tb_top.sv
`timescale 1ns/1ps
module rxRingPtrMgr_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostWrSel = 2'd0;
  logic [7:0]  hostWrData = 8'h00;
  logic        pktStart = 1'b0;
  logic        byteValid = 1'b0;
  logic        pktGood = 1'b0;
  logic        pktReject = 1'b0;
  logic [15:0] wrAddr;
  logic        overflowAbort;
  logic [7:0]  curPage;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the pointers
  logic [7:0] mFirst = 8'h40, mEnd = 8'h80, mLimit = 8'h40, mStart = 8'h41;
  logic [7:0] mPage = 8'h41, mOff = 8'h00;
  bit mActive = 1'b0;

  always #2.5 clk = ~clk;

  rxRingPtrMgr dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrSel(hostWrSel),
    .hostWrData(hostWrData), .pktStart(pktStart), .byteValid(byteValid),
    .pktGood(pktGood), .pktReject(pktReject), .wrAddr(wrAddr),
    .overflowAbort(overflowAbort), .curPage(curPage)
  );

  function automatic logic [7:0] nxt(input logic [7:0] p);
    logic [7:0] inc;
    inc = p + 8'd1;
    return (inc == mEnd) ? mFirst : inc;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWr(input logic [1:0] sel, input logic [7:0] data);
    hostWrEn = 1'b1; hostWrSel = sel; hostWrData = data;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (!mActive) begin
      case (sel)
        2'd0: mFirst = data;
        2'd1: mEnd = data;
        2'd2: mLimit = data;
        default: begin mStart = data; mPage = data; mOff = 8'h00; end
      endcase
    end
  endtask

  task automatic startPkt(input string req);
    pktStart = 1'b1;
    @(negedge clk);
    pktStart = 1'b0;
    if (!mActive) begin
      if (mStart == mLimit) begin
        chk(req, overflowAbort, 1);
      end else begin
        mActive = 1'b1; mPage = mStart; mOff = 8'h00;
        chk(req, overflowAbort, 0);
      end
    end
  endtask

  task automatic sendByte(input string req);
    logic [7:0] np;
    chk(req, wrAddr, {mPage, mOff});
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    if (mActive) begin
      if (mOff == 8'hFF) begin
        np = nxt(mPage);
        if (np == mLimit) begin
          chk("R4", overflowAbort, 1);
          mActive = 1'b0; mPage = mStart; mOff = 8'h00;
          chk("R4", wrAddr, {mPage, mOff});
        end else begin
          mPage = np; mOff = 8'h00;
        end
      end else begin
        mOff = mOff + 8'd1;
      end
    end
  endtask

  task automatic sendBytes(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      if (!mActive) break;
      sendByte(req);
    end
  endtask

  task automatic endPkt(input bit good, input bit rej, input bit withByte, input string req);
    pktGood = good; pktReject = rej; byteValid = withByte;
    @(negedge clk);
    pktGood = 1'b0; pktReject = 1'b0; byteValid = 1'b0;
    if (mActive) begin
      if (rej) begin
        mPage = mStart;
      end else if (good) begin
        mStart = (mOff == 8'h00) ? mPage : nxt(mPage);
        mPage = mStart;
      end
      mOff = 8'h00;
      mActive = 1'b0;
    end
    chk(req, curPage, mStart);
    chk(req, wrAddr, {mPage, mOff});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", wrAddr, 16'h4100);
    chk("R1", curPage, 8'h41);
    chk("R1", overflowAbort, 0);

    // R8: configure a four-page ring 0x10..0x13
    hostWr(2'd0, 8'h10);
    hostWr(2'd1, 8'h14);
    hostWr(2'd2, 8'h10);
    hostWr(2'd3, 8'h11);
    chk("R8", wrAddr, 16'h1100);

    // R2/R6: 300 bytes crossing one page
    startPkt("R2");
    sendBytes(300, "R2");
    endPkt(1, 0, 0, "R6");
    chk("R6", curPage, 8'h13);

    // R3: exactly one page from the last page wraps to the first
    hostWr(2'd2, 8'h12);
    startPkt("R3");
    sendBytes(256, "R3");
    chk("R3", wrAddr, 16'h1000);
    endPkt(1, 0, 0, "R6");
    chk("R6", curPage, 8'h10);

    // R4: run into the read-limit page at 0x12
    startPkt("R4");
    sendBytes(600, "R4");
    chk("R4", curPage, 8'h10);
    chk("R4", wrAddr, 16'h1000);
    @(negedge clk);
    chk("R4", overflowAbort, 0);
    // R9: byteValid while idle is ignored
    sendByte("R9");
    chk("R9", wrAddr, 16'h1000);

    // R7: rejected packet
    startPkt("R7");
    sendBytes(100, "R7");
    endPkt(0, 1, 0, "R7");
    chk("R7", wrAddr, 16'h1000);

    // R8: host writes during reception are ignored
    startPkt("R8");
    hostWr(2'd3, 8'h05);
    hostWr(2'd2, 8'h11);
    sendBytes(300, "R8");
    chk("R8", overflowAbort, 0);
    endPkt(1, 0, 0, "R8");
    chk("R8", curPage, 8'h12);

    // R5: start page equals read limit
    startPkt("R5");
    chk("R5", wrAddr, 16'h1200);
    @(negedge clk);
    chk("R5", overflowAbort, 0);

    // R9: reject beats good
    hostWr(2'd2, 8'h10);
    startPkt("R9");
    sendBytes(5, "R9");
    endPkt(1, 1, 0, "R9");
    chk("R9", curPage, 8'h12);
    // R9: byte in the commit cycle is not counted
    startPkt("R9");
    sendBytes(256, "R9");
    endPkt(1, 0, 1, "R9");
    chk("R9", curPage, 8'h13);

    // R6: empty packet leaves the start page
    startPkt("R6");
    endPkt(1, 0, 0, "R6");
    chk("R6", curPage, 8'h13);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule